// File: doc/BRIEF.md
# Segmented Code Prefetch Front End

This block is the fetch side of a 16-bit processor with segmented memory. It holds the code segment and the instruction pointer and turns them into 20-bit physical read addresses by shifting the segment left four places and adding the offset. While the execution side is busy, it reads code bytes one at a time over a byte-wide memory port into a small queue. The execution side takes bytes from that queue through a valid/ready handshake.

A taken branch loads a new code segment and instruction pointer. It empties the queue at once and restarts fetching at the target. If a read is still outstanding when the branch arrives, its byte is thrown away when it returns. A second address path forms data addresses. It picks the data or stack segment from the base register in use, unless an explicit segment override is given.

Top module: `seg_fetch_unit`

## Requirements
- R1: While reset is asserted, `mem_req` and `q_valid` are low. The first fetch after reset reads segment `RESET_CS` (0xFFFF) and offset `RESET_IP` (0x0000), which is physical address 0xFFFF0.
- R2: A physical address is (segment × 16 + offset) mod 2^20. Any carry out of bit 19 is dropped, so segment 0xFFFF with offset 0xFFFF gives 0x0FFEF.
- R3: Each fetch request reads code segment : instruction pointer, and the pointer then steps by one. The pointer wraps modulo 2^16, and the address wraps as in R2. From 0xFFFF:0x000F, the next fetch is at 0x00000.
- R4: The queue never holds more than `DEPTH` (6) bytes. When it is full, no fetch is issued. Fetching continues whenever there is room, even while the consumer does not pop.
- R5: Bytes leave the queue in the order they were fetched, lowest address first (little-endian order). A byte is removed in a cycle where `q_valid` and `q_ready` are both high.
- R6: In the cycle after `br_valid`, `q_valid` is low. The next request issued is to `br_cs`:`br_ip`.
- R7: If a read is outstanding when `br_valid` is seen, or its data returns in that same cycle, that byte is dropped and never reaches the queue.
- R8: With no override, the data segment is chosen from `da_base` as follows. Base codes 0 (BX), 1 (SI), 2 (DI) and 5 to 7 select `seg_ds`. Codes 3 (SP) and 4 (BP) select `seg_ss`.
- R9: With `da_ovr_en` high, the segment comes from `da_ovr_sel`: 0 = ES, 1 = CS (the current code segment), 2 = SS, 3 = DS. This replaces the default from R8.
- R10: At most one memory read is outstanding. `mem_req` is a one-cycle pulse and is not raised again until `mem_rvalid` has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 20 | Physical address of the read |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 8 | Returned code byte |
| q_valid | output | 1 | Queue holds a byte |
| q_byte | output | 8 | Oldest queued byte |
| q_ready | input | 1 | Consumer takes the byte |
| br_valid | input | 1 | Taken branch: flush and redirect |
| br_cs | input | 16 | Branch target segment |
| br_ip | input | 16 | Branch target offset |
| seg_ds | input | 16 | Data segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_es | input | 16 | Extra segment value |
| da_base | input | 3 | Base register code of the data access |
| da_off | input | 16 | Data offset |
| da_ovr_en | input | 1 | Segment override present |
| da_ovr_sel | input | 2 | Override segment select |
| da_paddr | output | 20 | Data physical address |

## Verification
The assertions check on every cycle that:
- only one read is ever outstanding;
- the request is a single-cycle pulse;
- the queue stays within its depth;
- the queue reads empty in the cycle after a branch;
- every fetch address matches an independent model of segment and pointer.

For stack-based and ES-override accesses, the assertions also check the data address against the selected segment.

Only the bench scenarios can show the rest:
- the order of the bytes delivered;
- that a stale byte from a read in flight at a branch never appears;
- the wraparound at the 1 MB and 64 KB boundaries;
- that the queue refills up to its depth with no consumer activity.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  localparam int SEG_W  = 16;
  localparam int OFF_W  = 16;
  localparam int PA_W   = 20;
  localparam int SHIFT  = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    BASE_BX = 3'd0,
    BASE_SI = 3'd1,
    BASE_DI = 3'd2,
    BASE_SP = 3'd3,
    BASE_BP = 3'd4
  } base_e;

  typedef enum logic [1:0] {
    SEL_ES = 2'd0,
    SEL_CS = 2'd1,
    SEL_SS = 2'd2,
    SEL_DS = 2'd3
  } seg_sel_e;
endpackage

// File: rtl/sfu_addr_gen.sv
module sfu_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int PA_W  = 20
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  pa
);
  logic [PA_W-1:0] seg_shifted;
  logic [PA_W-1:0] off_ext;

  // Sum is kept to PA_W bits; the carry out of the top bit is discarded.
  assign seg_shifted = PA_W'({seg, {SHIFT{1'b0}}});
  assign off_ext     = PA_W'(off);
  assign pa          = seg_shifted + off_ext;
endmodule

// File: rtl/sfu_seg_select.sv
module sfu_seg_select
  import sfu_pkg::*;
(
  input  logic [2:0]       base,
  input  logic             ovr_en,
  input  logic [1:0]       ovr_sel,
  input  logic [SEG_W-1:0] cs,
  input  logic [SEG_W-1:0] ds,
  input  logic [SEG_W-1:0] ss,
  input  logic [SEG_W-1:0] es,
  output logic [SEG_W-1:0] seg
);
  base_e    base_t;
  seg_sel_e sel_t;

  assign base_t = base_e'(base);
  assign sel_t  = seg_sel_e'(ovr_sel);

  always_comb begin
    if (ovr_en) begin
      unique case (sel_t)
        SEL_ES:  seg = es;
        SEL_CS:  seg = cs;
        SEL_SS:  seg = ss;
        default: seg = ds;
      endcase
    end else begin
      case (base_t)
        BASE_SP, BASE_BP: seg = ss;
        default:          seg = ds;
      endcase
    end
  end
endmodule

// File: rtl/sfu_byte_queue.sv
module sfu_byte_queue #(
  parameter int DEPTH = 6,
  parameter int W     = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             do_push, do_pop;

  assign do_push = push && (cnt_q != FULL) && !flush;
  assign do_pop  = pop && (cnt_q != '0) && !flush;

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (flush) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wr_n = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_n = (rd_q == LAST) ? '0 : rd_q + 1'b1;
      cnt_n = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store[wr_q] <= din;
  end

  assign dout  = store[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/sfu_fetch_ctrl.sv
module sfu_fetch_ctrl
  import sfu_pkg::*;
#(
  parameter int             DEPTH    = 6,
  parameter logic [15:0]    RESET_CS = 16'hFFFF,
  parameter logic [15:0]    RESET_IP = 16'h0000,
  localparam int            CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  input  logic [SEG_W-1:0] br_cs,
  input  logic [OFF_W-1:0] br_ip,
  input  logic             mem_rvalid,
  input  logic [CNT_W-1:0] q_count,
  output logic             push,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  output logic [SEG_W-1:0] cs
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [SEG_W-1:0] cs_q, cs_n;
  logic [OFF_W-1:0] ip_q, ip_n;
  logic             busy_q, busy_n;
  logic             stale_q, stale_n;
  logic             req_q, req_n;
  logic [PA_W-1:0]  addr_q, addr_n;
  logic [PA_W-1:0]  fetch_pa;
  logic             fire;

  sfu_addr_gen #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .PA_W(PA_W)
  ) u_fetch_ag (
    .seg(cs_q),
    .off(ip_q),
    .pa (fetch_pa)
  );

  assign fire = !busy_q && (q_count < FULL) && !br_valid;
  assign push = mem_rvalid && busy_q && !stale_q && !br_valid;

  always_comb begin
    cs_n    = cs_q;
    ip_n    = ip_q;
    busy_n  = busy_q;
    stale_n = stale_q;
    req_n   = fire;
    addr_n  = addr_q;
    if (fire) begin
      busy_n = 1'b1;
      addr_n = fetch_pa;
    end else if (mem_rvalid) begin
      busy_n = 1'b0;
    end
    if (mem_rvalid) begin
      stale_n = 1'b0;
    end else if (br_valid && busy_q) begin
      stale_n = 1'b1;
    end
    if (br_valid) begin
      cs_n = br_cs;
      ip_n = br_ip;
    end else if (fire) begin
      ip_n = ip_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= RESET_CS;
      ip_q    <= RESET_IP;
      busy_q  <= 1'b0;
      stale_q <= 1'b0;
      req_q   <= 1'b0;
      addr_q  <= '0;
    end else begin
      cs_q    <= cs_n;
      ip_q    <= ip_n;
      busy_q  <= busy_n;
      stale_q <= stale_n;
      req_q   <= req_n;
      addr_q  <= addr_n;
    end
  end

  assign mem_req  = req_q;
  assign mem_addr = addr_q;
  assign cs       = cs_q;
endmodule

// File: rtl/seg_fetch_unit.sv
module seg_fetch_unit
  import sfu_pkg::*;
#(
  parameter int          DEPTH    = 6,
  parameter logic [15:0] RESET_CS = 16'hFFFF,
  parameter logic [15:0] RESET_IP = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic [19:0]       mem_addr,
  input  logic              mem_rvalid,
  input  logic [7:0]        mem_rdata,
  output logic              q_valid,
  output logic [7:0]        q_byte,
  input  logic              q_ready,
  input  logic              br_valid,
  input  logic [15:0]       br_cs,
  input  logic [15:0]       br_ip,
  input  logic [15:0]       seg_ds,
  input  logic [15:0]       seg_ss,
  input  logic [15:0]       seg_es,
  input  logic [2:0]        da_base,
  input  logic [15:0]       da_off,
  input  logic              da_ovr_en,
  input  logic [1:0]        da_ovr_sel,
  output logic [19:0]       da_paddr
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             rst_s0, rst_s1, rst_sync_n;
  logic [CNT_W-1:0] q_count;
  logic             q_push;
  logic [SEG_W-1:0] cs_cur;
  logic [SEG_W-1:0] data_seg;

  // Reset asserts at once and releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end
  assign rst_sync_n = rst_s1;

  sfu_fetch_ctrl #(
    .DEPTH(DEPTH), .RESET_CS(RESET_CS), .RESET_IP(RESET_IP)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .br_valid  (br_valid),
    .br_cs     (br_cs),
    .br_ip     (br_ip),
    .mem_rvalid(mem_rvalid),
    .q_count   (q_count),
    .push      (q_push),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .cs        (cs_cur)
  );

  sfu_byte_queue #(.DEPTH(DEPTH), .W(BYTE_W)) u_queue (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .flush(br_valid),
    .push (q_push),
    .din  (mem_rdata),
    .pop  (q_ready),
    .dout (q_byte),
    .count(q_count)
  );

  assign q_valid = (q_count != '0);

  sfu_seg_select u_sel (
    .base   (da_base),
    .ovr_en (da_ovr_en),
    .ovr_sel(da_ovr_sel),
    .cs     (cs_cur),
    .ds     (seg_ds),
    .ss     (seg_ss),
    .es     (seg_es),
    .seg    (data_seg)
  );

  sfu_addr_gen #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .PA_W(PA_W)
  ) u_data_ag (
    .seg(data_seg),
    .off(da_off),
    .pa (da_paddr)
  );
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker #(
  parameter int          DEPTH    = 6,
  parameter int          CNT_W    = 3,
  parameter logic [15:0] RESET_CS = 16'hFFFF,
  parameter logic [15:0] RESET_IP = 16'h0000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic [19:0]      mem_addr,
  input logic             mem_rvalid,
  input logic             q_valid,
  input logic             br_valid,
  input logic [15:0]      br_cs,
  input logic [15:0]      br_ip,
  input logic [CNT_W-1:0] q_count,
  input logic [15:0]      seg_ss,
  input logic [15:0]      seg_es,
  input logic [2:0]       da_base,
  input logic [15:0]      da_off,
  input logic             da_ovr_en,
  input logic [1:0]       da_ovr_sel,
  input logic [19:0]      da_paddr
);
  logic        out_q;
  logic [15:0] m_cs, m_ip;
  logic [20:0] m_sum, ss_sum, es_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      m_cs  <= RESET_CS;
      m_ip  <= RESET_IP;
    end else begin
      if (mem_req) out_q <= 1'b1;
      else if (mem_rvalid) out_q <= 1'b0;
      if (br_valid) begin
        m_cs <= br_cs;
        m_ip <= br_ip;
      end else if (mem_req) begin
        m_ip <= m_ip + 16'd1;
      end
    end
  end

  always_comb begin
    m_sum  = {1'b0, m_cs, 4'h0} + {5'h00, m_ip};
    ss_sum = {1'b0, seg_ss, 4'h0} + {5'h00, da_off};
    es_sum = {1'b0, seg_es, 4'h0} + {5'h00, da_off};
  end

  assert_single_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !out_q);
  assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(DEPTH));
  assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> !q_valid);
  assert_fetch_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr == m_sum[19:0]));
  assert_stack_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!da_ovr_en && (da_base == 3'd3 || da_base == 3'd4)) |-> (da_paddr == ss_sum[19:0]));
  assert_es_override_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (da_ovr_en && da_ovr_sel == 2'd0) |-> (da_paddr == es_sum[19:0]));
endmodule

bind seg_fetch_unit sfu_checker #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .RESET_CS(RESET_CS), .RESET_IP(RESET_IP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_rvalid(mem_rvalid),
  .q_valid   (q_valid),
  .br_valid  (br_valid),
  .br_cs     (br_cs),
  .br_ip     (br_ip),
  .q_count   (q_count),
  .seg_ss    (seg_ss),
  .seg_es    (seg_es),
  .da_base   (da_base),
  .da_off    (da_off),
  .da_ovr_en (da_ovr_en),
  .da_ovr_sel(da_ovr_sel),
  .da_paddr  (da_paddr)
);

// File: tb/sim_seg_fetch_unit.sv
`timescale 1ns/1ps
module sim_seg_fetch_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_req, mem_rvalid;
  logic [19:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        q_valid, q_ready;
  logic [7:0]  q_byte;
  logic        br_valid;
  logic [15:0] br_cs, br_ip, seg_ds, seg_ss, seg_es, da_off;
  logic [2:0]  da_base;
  logic        da_ovr_en;
  logic [1:0]  da_ovr_sel;
  logic [19:0] da_paddr;

  always #2 clk = ~clk;

  seg_fetch_unit u0 (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .q_valid(q_valid),
    .q_byte(q_byte), .q_ready(q_ready), .br_valid(br_valid), .br_cs(br_cs),
    .br_ip(br_ip), .seg_ds(seg_ds), .seg_ss(seg_ss), .seg_es(seg_es),
    .da_base(da_base), .da_off(da_off), .da_ovr_en(da_ovr_en),
    .da_ovr_sel(da_ovr_sel), .da_paddr(da_paddr)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  function automatic logic [7:0] memf(input logic [19:0] a);
    return a[7:0] ^ a[19:12] ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  // Memory model: one read at a time, latency set by mem_lat.
  int          mem_lat  = 1;
  int          pend_cnt = 0;
  logic [19:0] pend_addr;
  logic [19:0] req_log [0:255];
  int          n_req    = 0;
  int          proto_err = 0;
  logic        prev_req = 1'b0;

  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = 8'h00;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (pend_cnt == 1) begin
        mem_rvalid = 1'b1;
        mem_rdata  = memf(pend_addr);
      end
      if (pend_cnt > 0) pend_cnt--;
      if (mem_req === 1'b1) begin
        if (pend_cnt > 0 || prev_req) proto_err++;
        if (n_req < 256) req_log[n_req] = mem_addr;
        n_req++;
        pend_addr = mem_addr;
        pend_cnt  = mem_lat;
      end
      prev_req = (mem_req === 1'b1);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run hung actual=timeout expected=completion");
    finish_run();
  end

  task automatic pop_byte(input logic [19:0] exp_addr, input string req);
    int waited = 0;
    while (q_valid !== 1'b1 && waited < 400) begin
      @(negedge clk);
      waited++;
    end
    check(q_valid === 1'b1 && q_byte === memf(exp_addr), req,
          {23'd0, q_valid, q_byte}, {24'd1, memf(exp_addr)});
    q_ready = 1'b1;
    @(negedge clk);
    q_ready = 1'b0;
  endtask

  task automatic do_flush(input logic [15:0] c, input logic [15:0] i);
    br_valid = 1'b1;
    br_cs    = c;
    br_ip    = i;
    @(negedge clk);
    br_valid = 1'b0;
    check(q_valid === 1'b0, "R6 empty after flush", {31'd0, q_valid}, 32'd0);
  endtask

  // {base, ovr_en, ovr_sel, offset, expected}; DS=2000 SS=3000 ES=4000 CS=FFFF
  localparam int NV = 10;
  localparam logic [41:0] VEC [0:NV-1] = '{
    {3'd0, 1'b0, 2'd0, 16'h0050, 20'h20050},   // R2 R8 BX -> DS
    {3'd1, 1'b0, 2'd0, 16'h1234, 20'h21234},   // R8 SI -> DS
    {3'd2, 1'b0, 2'd0, 16'hFFFF, 20'h2FFFF},   // R8 DI -> DS
    {3'd3, 1'b0, 2'd0, 16'h0100, 20'h30100},   // R8 SP -> SS
    {3'd4, 1'b0, 2'd0, 16'h8000, 20'h38000},   // R8 BP -> SS
    {3'd6, 1'b0, 2'd0, 16'h0007, 20'h20007},   // R8 spare code -> DS
    {3'd0, 1'b1, 2'd0, 16'h0010, 20'h40010},   // R9 override ES
    {3'd4, 1'b1, 2'd3, 16'h0002, 20'h20002},   // R9 override DS on BP
    {3'd1, 1'b1, 2'd2, 16'h0003, 20'h30003},   // R9 override SS on SI
    {3'd2, 1'b1, 2'd1, 16'h0020, 20'h00010}    // R9 R2 override CS, wraps
  };

  initial begin
    logic [19:0] inflight;
    int          idx;
    rst_n = 1'b0; q_ready = 1'b0; br_valid = 1'b0; br_cs = '0; br_ip = '0;
    seg_ds = 16'h2000; seg_ss = 16'h3000; seg_es = 16'h4000;
    da_base = '0; da_off = '0; da_ovr_en = 1'b0; da_ovr_sel = '0;
    repeat (3) @(negedge clk);
    check(mem_req === 1'b0 && q_valid === 1'b0, "R1 reset outputs",
          {30'd0, mem_req, q_valid}, 32'd0);
    rst_n = 1'b1;

    // Fill with no consumer activity
    repeat (80) @(negedge clk);
    check(n_req == 6, "R4 fills to depth then stops", n_req, 6);
    check(req_log[0] == 20'hFFFF0, "R1 first fetch address", req_log[0], 20'hFFFF0);
    check(req_log[5] == 20'hFFFF5, "R3 sequential fetch", req_log[5], 20'hFFFF5);
    check(q_valid === 1'b1, "R4 queue holds bytes", {31'd0, q_valid}, 32'd1);

    // Data address vectors
    for (int v = 0; v < NV; v++) begin
      {da_base, da_ovr_en, da_ovr_sel, da_off} = VEC[v][41:20];
      @(negedge clk);
      check(da_paddr == VEC[v][19:0], "R2/R8/R9 data address vector",
            da_paddr, VEC[v][19:0]);
    end
    seg_ds = 16'hFFFF; da_base = 3'd0; da_ovr_en = 1'b0; da_off = 16'hFFFF;
    @(negedge clk);
    check(da_paddr == 20'h0FFEF, "R2 carry dropped", da_paddr, 20'h0FFEF);
    seg_ds = 16'h2000;

    // Drain across the 1 MB boundary
    for (int k = 0; k < 20; k++) pop_byte(20'(20'hFFFF0 + k), "R5 R3 order and wrap");

    // Branch with a read in flight: stale byte must not appear
    mem_lat = 4;
    while (mem_req !== 1'b1) begin
      q_ready = q_valid;
      @(negedge clk);
    end
    q_ready = 1'b0;
    inflight = mem_addr;
    do_flush(16'h1000, 16'h0200);
    pop_byte(20'h10200, "R7 stale dropped, R6 restart");
    idx = -1;
    for (int j = 0; j < 256 && j < n_req; j++)
      if (idx < 0 && req_log[j] == 20'h10200) idx = j;
    check(idx > 0 && req_log[(idx > 0) ? idx - 1 : 0] == inflight,
          "R6 next request is the target", (idx > 0) ? req_log[idx - 1] : 20'h0, inflight);
    for (int k = 1; k < 6; k++) pop_byte(20'(20'h10200 + k), "R5 order after branch");

    // CS override follows the new code segment
    da_base = 3'd2; da_ovr_en = 1'b1; da_ovr_sel = 2'd1; da_off = 16'h0020;
    @(negedge clk);
    check(da_paddr == 20'h10020, "R9 CS override uses code segment", da_paddr, 20'h10020);

    // Offset wrap inside segment zero
    mem_lat = 2;
    do_flush(16'h0000, 16'hFFFE);
    pop_byte(20'h0FFFE, "R3 offset before wrap");
    pop_byte(20'h0FFFF, "R3 offset at top");
    pop_byte(20'h00000, "R3 offset wraps to zero");

    repeat (20) @(negedge clk);
    check(proto_err == 0, "R10 single outstanding pulse", proto_err, 0);
    finish_run();
  end
endmodule